// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a handful of recent page-to-frame mappings so that most address translations avoid a trip to the in-memory page table. A requester presents a page number. The block compares it against the key of every valid entry at once. On a match it returns the stored frame number and status flags combinationally, in the same cycle. A hit therefore adds no memory access before the data access.

When no entry matches, the block raises a walk request toward an external page table walker and holds it until the walker answers. This costs one extra memory access. The walker's answer is forwarded to the requester in the cycle it arrives. The answer is written into the buffer unless it reports a fault. The victim entry is the lowest-numbered invalid entry if there is one. Otherwise a round-robin pointer chooses it. A flush input invalidates every entry in one cycle, which suits a context switch.

Two free-running counters, one for hits and one for misses, let the hit ratio be measured. The average access time is roughly the lookup time plus one memory cycle, plus one more memory cycle scaled by the miss fraction. For example, with a 20 ns lookup and a 100 ns memory cycle, a 98% hit ratio averages 122 ns.

Top module: `xlat_buf`

## Requirements
- R1: After reset no entry is valid, `lk_ready` is 1, `walk_req` is 0, and both counters read 0.
- R2: When `lk_ready` is 1 and `lk_valid` is 1 with a page that equals the key of a valid entry, and `flush` is 0, `lk_hit` is 1 in that same cycle, with `lk_frame` and `lk_flags` equal to that entry's stored values.
- R3: An accepted lookup that misses makes `walk_req` 1 from the next cycle on, with `walk_page` equal to the missed page. `lk_ready` stays 0 until the walker answers.
- R4: While a walk is pending, `lk_valid` is ignored: `lk_hit` stays 0 and neither counter changes.
- R5: In the cycle `walk_rsp_valid` is 1 during a walk, `fill_valid` is 1 and `fill_frame`, `fill_flags` and `fill_fault` carry the walker's values. In the next cycle `walk_req` is 0 and `lk_ready` is 1.
- R6: A walker answer with `walk_fault` at 0 is installed, so a later lookup of the same page hits with the returned frame and flags.
- R7: A walker answer with `walk_fault` at 1 is not installed, so a later lookup of that page misses again.
- R8: An install goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the entry chosen by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, after each such replacement.
- R9: `flush` at 1 invalidates all entries at the next edge. A lookup in the flush cycle counts as a miss and starts a walk. An install in the flush cycle is dropped.
- R10: `hit_count` rises by one after each accepted hit, and `miss_count` rises by one after each accepted miss. Both wrap at their width.

Reset is an asynchronous active-low input. It is released through a two-stage synchronizer, so the block leaves reset on the second rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_page | input | PAGE_W | Page number to translate |
| lk_ready | output | 1 | Block is idle and accepts a lookup |
| lk_hit | output | 1 | Lookup hit this cycle |
| lk_frame | output | FRAME_W | Frame number on hit |
| lk_flags | output | FLAG_W | Status flags on hit |
| walk_req | output | 1 | Request to page table walker |
| walk_page | output | PAGE_W | Page to walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_frame | input | FRAME_W | Frame from walker |
| walk_flags | input | FLAG_W | Flags from walker |
| walk_fault | input | 1 | Walker reports a fault |
| fill_valid | output | 1 | Miss result to requester |
| fill_frame | output | FRAME_W | Frame of miss result |
| fill_flags | output | FLAG_W | Flags of miss result |
| fill_fault | output | 1 | Fault of miss result |
| hit_count | output | CNT_W | Accepted hits |
| miss_count | output | CNT_W | Accepted misses |

## Verification
Some faults corrupt the valid bits or the stored keys. They show up the first time the affected page is looked up, as a hit where a miss was due or the reverse. A wrong frame shows up in that same cycle on `lk_frame`. A bad replacement pointer shows up a few lookups after the buffer fills, when a page expected to survive misses. The stimulus table therefore walks the buffer through fill, wrap-around and re-reference. A stuck controller state shows up within one cycle, as `lk_ready` or `walk_req` at the wrong level, and every walk is checked on both edges.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } xlat_state_e;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 16,
  parameter int FLAG_W  = 3,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [FLAG_W-1:0]  wr_flags,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               match_any,
  output logic [FRAME_W-1:0] match_frame,
  output logic [FLAG_W-1:0]  match_flags,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [PAGE_W-1:0]  key_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [FLAG_W-1:0]  flags_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  always_comb begin
    valid_d = valid_q;
    if (flush) begin
      valid_d = '0;
    end else if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_entry
      logic sel;
      assign sel = wr_en && !flush && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk) begin
        if (sel) begin
          key_q[g]   <= wr_page;
          frame_q[g] <= wr_frame;
          flags_q[g] <= wr_flags;
        end
      end
      assign hit_vec[g] = valid_q[g] && (key_q[g] == lk_page);
    end
  endgenerate

  always_comb begin
    match_frame = '0;
    match_flags = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        match_frame = frame_q[i];
        match_flags = flags_q[i];
      end
    end
  end

  assign match_any = |hit_vec;
  assign valid_vec = valid_q;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             all_valid;

  assign all_valid = &valid_vec;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim_idx = all_valid ? rr_q : free_idx;

  always_comb begin
    rr_d = rr_q;
    if (advance && all_valid) begin
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else begin
      rr_q <= rr_d;
    end
  end
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [PAGE_W-1:0] lk_page,
  input  logic              match_any,
  input  logic              walk_rsp_valid,
  input  logic              walk_fault,
  output logic              lk_ready,
  output logic              lk_hit,
  output logic              walk_req,
  output logic [PAGE_W-1:0] walk_page,
  output logic              fill_valid,
  output logic              install_en,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  xlat_state_e       state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  hits_q, hits_d, miss_q, miss_d;
  logic              accept, miss, page_en;

  assign lk_ready = (state_q == ST_IDLE);
  assign accept   = lk_valid && lk_ready;
  assign lk_hit   = accept && match_any && !flush;
  assign miss     = accept && !lk_hit;
  assign page_en  = miss;

  assign walk_req   = (state_q == ST_WALK);
  assign walk_page  = page_q;
  assign fill_valid = walk_req && walk_rsp_valid;
  assign install_en = fill_valid && !walk_fault && !flush;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (miss) state_d = ST_WALK;
      ST_WALK: if (walk_rsp_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    hits_d = hits_q;
    miss_d = miss_q;
    if (lk_hit) hits_d = hits_q + 1'b1;
    if (miss)   miss_d = miss_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hits_q  <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      hits_q  <= hits_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk) begin
    if (page_en) begin
      page_q <= lk_page;
    end
  end

  assign hit_count  = hits_q;
  assign miss_count = miss_q;
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 16,
  parameter int FLAG_W  = 3,
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               lk_valid,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               lk_ready,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic [FLAG_W-1:0]  lk_flags,
  output logic               walk_req,
  output logic [PAGE_W-1:0]  walk_page,
  input  logic               walk_rsp_valid,
  input  logic [FRAME_W-1:0] walk_frame,
  input  logic [FLAG_W-1:0]  walk_flags,
  input  logic               walk_fault,
  output logic               fill_valid,
  output logic [FRAME_W-1:0] fill_frame,
  output logic [FLAG_W-1:0]  fill_flags,
  output logic               fill_fault,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   miss_count
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic               rst_meta_q, rst_sync_n;
  logic               match_any, install_en;
  logic [IDX_W-1:0]   victim_idx;
  logic [ENTRIES-1:0] valid_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  xlat_cam #(
    .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .FLAG_W(FLAG_W), .ENTRIES(ENTRIES)
  ) u_cam (
    .clk(clk), .rst_n(rst_sync_n), .flush(flush),
    .wr_en(install_en), .wr_idx(victim_idx), .wr_page(walk_page),
    .wr_frame(walk_frame), .wr_flags(walk_flags), .lk_page(lk_page),
    .match_any(match_any), .match_frame(lk_frame), .match_flags(lk_flags),
    .valid_vec(valid_vec)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_sync_n), .valid_vec(valid_vec),
    .advance(install_en), .victim_idx(victim_idx)
  );

  xlat_ctrl #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .flush(flush),
    .lk_valid(lk_valid), .lk_page(lk_page), .match_any(match_any),
    .walk_rsp_valid(walk_rsp_valid), .walk_fault(walk_fault),
    .lk_ready(lk_ready), .lk_hit(lk_hit), .walk_req(walk_req),
    .walk_page(walk_page), .fill_valid(fill_valid), .install_en(install_en),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  assign fill_frame = walk_frame;
  assign fill_flags = walk_flags;
  assign fill_fault = walk_fault;
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int PAGE_W = 20,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              flush,
  input logic              lk_valid,
  input logic [PAGE_W-1:0] lk_page,
  input logic              lk_ready,
  input logic              lk_hit,
  input logic              walk_req,
  input logic [PAGE_W-1:0] walk_page,
  input logic              fill_valid,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  // R3
  walk_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_valid && lk_ready && !lk_hit) |=> (walk_req && walk_page == $past(lk_page)));

  // R4
  no_hit_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_ready |-> !lk_hit);

  // R4
  busy_counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_ready |=> ($stable(hit_count) && $stable(miss_count)));

  // R5
  fill_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_valid |-> walk_req);

  // R5
  ready_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_valid |=> (lk_ready && !walk_req));

  // R9
  flush_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |-> !lk_hit);

  // R10
  hit_count_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_hit |=> (hit_count == $past(hit_count) + CNT_W'(1)));

  // R10
  miss_count_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_valid && lk_ready && !lk_hit) |=> (miss_count == $past(miss_count) + CNT_W'(1)));
endmodule

bind xlat_buf xlat_buf_chk #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .flush(flush), .lk_valid(lk_valid),
  .lk_page(lk_page), .lk_ready(lk_ready), .lk_hit(lk_hit), .walk_req(walk_req),
  .walk_page(walk_page), .fill_valid(fill_valid), .hit_count(hit_count),
  .miss_count(miss_count)
);

// File: tb/xlat_buf_tb.sv
module xlat_buf_tb;
  localparam int PW = 20, FW = 16, GW = 3, NE = 4, CW = 16;

  logic clk, rst_n, flush, lk_valid, lk_ready, lk_hit, walk_req;
  logic walk_rsp_valid, walk_fault, fill_valid, fill_fault;
  logic [PW-1:0] lk_page, walk_page;
  logic [FW-1:0] lk_frame, walk_frame, fill_frame;
  logic [GW-1:0] lk_flags, walk_flags, fill_flags;
  logic [CW-1:0] hit_count, miss_count;
  int checks = 0, errors = 0, cycles = 0;

  xlat_buf #(.PAGE_W(PW), .FRAME_W(FW), .FLAG_W(GW), .ENTRIES(NE), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_page(lk_page),
    .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_frame(lk_frame), .lk_flags(lk_flags),
    .walk_req(walk_req), .walk_page(walk_page), .walk_rsp_valid(walk_rsp_valid),
    .walk_frame(walk_frame), .walk_flags(walk_flags), .walk_fault(walk_fault),
    .fill_valid(fill_valid), .fill_frame(fill_frame), .fill_flags(fill_flags),
    .fill_fault(fill_fault), .hit_count(hit_count), .miss_count(miss_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [FW-1:0] fr(input logic [PW-1:0] p);
    return {p[7:0], ~p[7:0]};
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one lookup; on a miss the bench plays the walker
  task automatic do_lookup(input logic [PW-1:0] pg, input bit exp_hit, input bit flt,
                           input bit fl, input bit probe);
    @(negedge clk);
    lk_valid = 1'b1; lk_page = pg; flush = fl;
    #1;
    chk(lk_hit == exp_hit, exp_hit ? "R2 hit" : "R9/R8 miss", lk_hit, exp_hit);
    if (exp_hit) begin
      chk(lk_frame == fr(pg), "R2/R6 frame", lk_frame, fr(pg));
      chk(lk_flags == pg[2:0], "R2/R6 flags", lk_flags, pg[2:0]);
    end
    @(negedge clk);
    lk_valid = 1'b0; flush = 1'b0;
    if (!exp_hit) begin
      #1;
      chk(walk_req == 1'b1, "R3 walk_req", walk_req, 1);
      chk(walk_page == pg, "R3 walk_page", walk_page, pg);
      chk(lk_ready == 1'b0, "R3 busy", lk_ready, 0);
      if (probe) begin
        lk_valid = 1'b1; lk_page = 20'h11;
        #1;
        chk(lk_hit == 1'b0, "R4 ignored", lk_hit, 0);
      end
      @(negedge clk);
      lk_valid = 1'b0;
      walk_rsp_valid = 1'b1; walk_frame = fr(pg); walk_flags = pg[2:0]; walk_fault = flt;
      #1;
      chk(fill_valid == 1'b1, "R5 fill_valid", fill_valid, 1);
      chk(fill_frame == fr(pg) && fill_fault == flt, "R5 fill data",
          {fill_fault, fill_frame}, {flt, fr(pg)});
      @(negedge clk);
      walk_rsp_valid = 1'b0; walk_fault = 1'b0;
      #1;
      chk(lk_ready == 1'b1 && walk_req == 1'b0, "R5 idle after fill",
          {lk_ready, walk_req}, 2'b10);
    end
  endtask

  // bit 20 = expected hit, bits 19:0 = page (4 entries)
  localparam logic [20:0] VEC [13] = '{
    {1'b0, 20'h10}, {1'b1, 20'h10}, {1'b0, 20'h11}, {1'b0, 20'h12},
    {1'b0, 20'h13}, {1'b1, 20'h11}, {1'b0, 20'h14}, {1'b0, 20'h10},
    {1'b0, 20'h11}, {1'b1, 20'h13}, {1'b1, 20'h14}, {1'b0, 20'h12},
    {1'b0, 20'h13}
  };

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; lk_valid = 1'b0; lk_page = '0;
    walk_rsp_valid = 1'b0; walk_frame = '0; walk_flags = '0; walk_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lk_ready == 1'b1 && walk_req == 1'b0, "R1 idle", {lk_ready, walk_req}, 2'b10);
    chk(hit_count == 0 && miss_count == 0, "R1 counters", {hit_count, miss_count}, 0);
    lk_valid = 1'b1; lk_page = 20'h10; #1;
    chk(lk_hit == 1'b0, "R1 empty", lk_hit, 0);
    lk_valid = 1'b0;

    // R8 fill, wrap and round-robin replacement
    for (int i = 0; i < 13; i++) begin
      do_lookup(VEC[i][19:0], VEC[i][20], 1'b0, 1'b0, 1'b0);
    end
    #1;
    chk(hit_count == 4, "R10 hits", hit_count, 4);
    chk(miss_count == 9, "R10 misses", miss_count, 9);

    // R4 lookup during walk ignored
    do_lookup(20'h40, 1'b0, 1'b0, 1'b0, 1'b1);
    #1;
    chk(hit_count == 4 && miss_count == 10, "R4 counters", {hit_count, miss_count},
        {16'd4, 16'd10});
    do_lookup(20'h40, 1'b1, 1'b0, 1'b0, 1'b0);

    // R7 fault not installed, R6 later install hits
    do_lookup(20'h2f, 1'b0, 1'b1, 1'b0, 1'b0);
    do_lookup(20'h2f, 1'b0, 1'b0, 1'b0, 1'b0);
    do_lookup(20'h2f, 1'b1, 1'b0, 1'b0, 1'b0);

    // R9 flush: lookup in flush cycle misses, earlier entries gone
    do_lookup(20'h2f, 1'b0, 1'b0, 1'b1, 1'b0);
    do_lookup(20'h40, 1'b0, 1'b0, 1'b0, 1'b0);
    do_lookup(20'h2f, 1'b1, 1'b0, 1'b0, 1'b0);
    summary();
  end
endmodule